// File: doc/BRIEF.md
# Buffered UART Peripheral

This block is a memory-mapped serial port with a transmit buffer and a receive buffer between the register bus and the line. Software writes data words into the transmit buffer. The transmitter serialises each word as one frame. The frame has a low start bit, then the data bits least-significant first, then an optional even parity bit, then one or two high stop bits. The receiver oversamples the incoming line at sixteen times the bit rate and confirms the start bit at its centre. It samples every later bit at mid-bit and stores each clean frame in the receive buffer, where software reads it back.

Word length, stop-bit count, parity and the clock divisor are all set through registers. A two-bit bus-behaviour field in the control register decides what happens when software writes a full transmit buffer or reads an empty receive buffer. The access can be held off, answered with an error, answered with a retry, or completed at once.

The register bus is a simple request/response handshake. The requester holds `req` and the other request fields steady until one of `ack`, `err` or `retry` pulses for a single cycle. It then drops `req`.

Top module: `buf_uart`

## Requirements
- R1: The 32-bit divisor register at offset 0x04 resets to `DIV_RESET` and reads back what was written. The oversampling tick comes once every max(divisor,1) clocks, and one serial bit lasts 16 ticks.
- R2: The control/status register at offset 0x08 reads as follows: bit 0 is transmit buffer empty, bit 1 is transmit buffer full, bit 2 is receive buffer empty, bit 3 is receive buffer full, bit 4 is parity enable, bit 5 reads 0, and bits 7:6 hold the bus-behaviour code. After reset it reads 0x05.
- R3: The word-length register at offset 0x14 stores its written value clamped to the range 5..8, and resets to 8. The stop-bit register at offset 0x18 reads 2 after a write of 2 or more and reads 1 otherwise, and resets to 1.
- R4: `txd` idles high. Each word written to offset 0x00 leaves as one frame, in write order: a low start bit, the data bits LSB first, an optional parity bit, then the configured number of high stop bits.
- R5: With bit 4 of the control register set, the transmitter adds a parity bit that makes the count of ones across data and parity even. The receiver rejects a frame whose parity is odd.
- R6: Received frames are read from offset 0x00 in arrival order, with the unused upper data bits at 0. Offset 0x0C reads the number of words held in the receive buffer, and offset 0x10 reads the number held in the transmit buffer.
- R7: With bus-behaviour code 1, a read of an empty receive buffer or a write to a full transmit buffer is answered with `err`. Neither buffer changes.
- R8: With bus-behaviour code 2, the same accesses are answered with `retry`. Neither buffer changes.
- R9: With bus-behaviour code 3, the same accesses are acknowledged at once. The read returns 0 and the written word is discarded.
- R10: With bus-behaviour code 0, the same accesses get no response until the buffer gains a free slot or a word. They then complete normally.
- R11: Writes to bits 3:0 of the control register are ignored, and those bits always show the live buffer state.
- R12: A received frame with bad parity or with a low stop bit is dropped. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R13: The transmit buffer holds `FIFO_DEPTH` words, and the full flag rises once it holds that many.
- R14: Every accepted request gets exactly one single-cycle pulse on exactly one of `ack`, `err` and `retry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus request, held until a response pulse |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `ack` |
| ack | output | 1 | Access completed |
| err | output | 1 | Access refused with error |
| retry | output | 1 | Access refused, try again |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench builds the block with `FIFO_DEPTH=4`, `DIV_RESET=1` and `SYNC_STAGES=2`. With a divisor of 1, every clock is an oversampling tick and a bit lasts 16 clocks, so a whole frame fits in under 200 cycles. That lets the bench check every bit of the line against its own decoder. A four-word transmit buffer fills after five quick writes, one word being taken at once by the shifter. This brings the full flag, the held-off write and the discarded write within a few hundred cycles. The two-stage synchroniser is the variant a real asynchronous line needs, and the bench drives the receive line both from the block's own output and directly, so it can send frames with bad parity or a bad stop bit.

// File: rtl/buf_uart_pkg.sv
package buf_uart_pkg;

   // Bus-behaviour codes held in control bits 7:6.
   typedef enum logic [1:0] {
      BB_STALL = 2'd0,
      BB_ERROR = 2'd1,
      BB_RETRY = 2'd2,
      BB_ACK   = 2'd3
   } bus_mode_e;

   // Kind of response issued on the register bus.
   typedef enum logic [1:0] {
      RK_NONE,
      RK_ACK,
      RK_ERR,
      RK_RTY
   } resp_e;

   // Shared line-engine states.
   typedef enum logic [2:0] {
      LS_IDLE,
      LS_START,
      LS_DATA,
      LS_PAR,
      LS_STOP,
      LS_HOLD
   } line_state_e;

   // Register word indices (addr[4:2]).
   localparam logic [2:0] IX_DATA  = 3'd0;
   localparam logic [2:0] IX_DIV   = 3'd1;
   localparam logic [2:0] IX_CTRL  = 3'd2;
   localparam logic [2:0] IX_RXCNT = 3'd3;
   localparam logic [2:0] IX_TXCNT = 3'd4;
   localparam logic [2:0] IX_SIZE  = 3'd5;
   localparam logic [2:0] IX_STOP  = 3'd6;

   function automatic logic [3:0] clamp_size(input logic [7:0] v);
      if (v < 8'd5) return 4'd5;
      if (v > 8'd8) return 4'd8;
      return v[3:0];
   endfunction

   function automatic logic pick_two_stop(input logic [7:0] v);
      return (v >= 8'd2);
   endfunction

endpackage

// File: rtl/buf_uart_fifo.sv
module buf_uart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];
   assign count   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= step(wptr);
         if (do_pop)  rptr <= step(rptr);
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

endmodule

// File: rtl/buf_uart_tick.sv
module buf_uart_tick #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] div,
   output logic          tick
);

   logic [DW-1:0] cnt;
   logic [DW-1:0] lim;

   assign lim = (div == '0) ? DW'(1) : div;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt + 1'b1 >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/buf_uart_tx.sv
module buf_uart_tx
   import buf_uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       have,
   input  logic [7:0] data,
   input  logic [3:0] nbits,
   input  logic       par_en,
   input  logic       two_stop,
   output logic       pop,
   output logic       txd
);

   line_state_e st;
   logic [3:0]  sub, bitn, n_q;
   logic [7:0]  sh, mask;
   logic        pbit, par_q, two_q, stop2;

   always_comb begin
      for (int i = 0; i < 8; i++) mask[i] = (4'(i) < nbits);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= LS_IDLE;
         txd   <= 1'b1;
         pop   <= 1'b0;
         sub   <= '0;
         bitn  <= '0;
         n_q   <= 4'd8;
         sh    <= '0;
         pbit  <= 1'b0;
         par_q <= 1'b0;
         two_q <= 1'b0;
         stop2 <= 1'b0;
      end else begin
         pop <= 1'b0;
         if (st == LS_IDLE) begin
            if (have) begin
               pop   <= 1'b1;
               sh    <= data;
               pbit  <= ^(data & mask);
               n_q   <= nbits;
               par_q <= par_en;
               two_q <= two_stop;
               sub   <= '0;
               txd   <= 1'b0;
               st    <= LS_START;
            end
         end else if (tick) begin
            sub <= sub + 1'b1;
            if (sub == 4'd15) begin
               case (st)
                  LS_START: begin
                     st   <= LS_DATA;
                     txd  <= sh[0];
                     bitn <= '0;
                  end
                  LS_DATA: begin
                     if (bitn == n_q - 4'd1) begin
                        stop2 <= 1'b0;
                        if (par_q) begin
                           st  <= LS_PAR;
                           txd <= pbit;
                        end else begin
                           st  <= LS_STOP;
                           txd <= 1'b1;
                        end
                     end else begin
                        sh   <= sh >> 1;
                        txd  <= sh[1];
                        bitn <= bitn + 1'b1;
                     end
                  end
                  LS_PAR: begin
                     st  <= LS_STOP;
                     txd <= 1'b1;
                  end
                  LS_STOP: begin
                     if (two_q && !stop2) stop2 <= 1'b1;
                     else                 st    <= LS_IDLE;
                  end
                  default: st <= LS_IDLE;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/buf_uart_rx.sv
module buf_uart_rx
   import buf_uart_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic [3:0] nbits,
   input  logic       par_en,
   input  logic       two_stop,
   output logic       push,
   output logic [7:0] word
);

   logic rxs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxs = rxd;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s1;
         always_ff @(posedge clk) begin
            if (!rst_n) s1 <= 1'b1;
            else        s1 <= rxd;
         end
         assign rxs = s1;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sy;
         always_ff @(posedge clk) begin
            if (!rst_n) sy <= '1;
            else        sy <= {sy[SYNC_STAGES-2:0], rxd};
         end
         assign rxs = sy[SYNC_STAGES-1];
      end
   endgenerate

   line_state_e st;
   logic [3:0]  sub, bitn, n_q;
   logic [7:0]  sh;
   logic        par_q, two_q, stop2, perr;

   assign word = sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= LS_IDLE;
         sub   <= '0;
         bitn  <= '0;
         n_q   <= 4'd8;
         sh    <= '0;
         par_q <= 1'b0;
         two_q <= 1'b0;
         stop2 <= 1'b0;
         perr  <= 1'b0;
         push  <= 1'b0;
      end else begin
         push <= 1'b0;
         case (st)
            LS_IDLE: begin
               if (!rxs) begin
                  st  <= LS_START;
                  sub <= '0;
               end
            end
            LS_START: if (tick) begin
               sub <= sub + 1'b1;
               if (sub == 4'd7) begin
                  sub <= '0;
                  if (!rxs) begin
                     st    <= LS_DATA;
                     bitn  <= '0;
                     sh    <= '0;
                     perr  <= 1'b0;
                     n_q   <= nbits;
                     par_q <= par_en;
                     two_q <= two_stop;
                  end else begin
                     st <= LS_IDLE;
                  end
               end
            end
            LS_DATA: if (tick) begin
               sub <= sub + 1'b1;
               if (sub == 4'd15) begin
                  sh[bitn[2:0]] <= rxs;
                  if (bitn == n_q - 4'd1) begin
                     stop2 <= 1'b0;
                     st    <= par_q ? LS_PAR : LS_STOP;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end
            end
            LS_PAR: if (tick) begin
               sub <= sub + 1'b1;
               if (sub == 4'd15) begin
                  perr <= (^sh) ^ rxs;
                  st   <= LS_STOP;
               end
            end
            LS_STOP: if (tick) begin
               sub <= sub + 1'b1;
               if (sub == 4'd15) begin
                  if (!rxs) begin
                     st <= LS_HOLD;
                  end else if (two_q && !stop2) begin
                     stop2 <= 1'b1;
                  end else begin
                     st   <= LS_IDLE;
                     push <= !perr;
                  end
               end
            end
            LS_HOLD: if (rxs) st <= LS_IDLE;
            default: st <= LS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/buf_uart.sv
module buf_uart
   import buf_uart_pkg::*;
#(
   parameter int          FIFO_DEPTH  = 8,
   parameter logic [31:0] DIV_RESET   = 32'd16,
   parameter int          SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        we,
   input  logic [4:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        ack,
   output logic        err,
   output logic        retry,
   output logic        txd,
   input  logic        rxd
);

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("buf_uart: FIFO_DEPTH must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("buf_uart: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   // Configuration state
   logic [31:0] div_q;
   logic        par_q, two_q;
   logic [3:0]  size_q;
   bus_mode_e   mode_q;

   // Buffer signals
   logic             tx_push, tx_pop, tx_full, tx_empty;
   logic             rx_push, rx_pop, rx_full, rx_empty;
   logic [7:0]       tx_head, rx_head, rx_word;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tick;

   // Bus decode
   logic [2:0]  idx;
   logic        resp_any, take, is_data, blocked, wr_cfg;
   resp_e       rk;
   logic [31:0] rd_mux;
   logic        unused_addr;

   assign idx         = addr[4:2];
   assign unused_addr = ^addr[1:0];
   assign resp_any    = ack | err | retry;
   assign take        = req && !resp_any;
   assign is_data     = (idx == IX_DATA);
   assign blocked     = is_data && (we ? tx_full : rx_empty);

   always_comb begin
      rk      = RK_NONE;
      tx_push = 1'b0;
      rx_pop  = 1'b0;
      if (take) begin
         if (blocked) begin
            case (mode_q)
               BB_ERROR: rk = RK_ERR;
               BB_RETRY: rk = RK_RTY;
               BB_ACK:   rk = RK_ACK;
               default:  rk = RK_NONE;
            endcase
         end else begin
            rk = RK_ACK;
            if (is_data) begin
               tx_push = we;
               rx_pop  = !we;
            end
         end
      end
   end

   assign wr_cfg = (rk == RK_ACK) && we && !is_data;

   always_comb begin
      case (idx)
         IX_DATA:  rd_mux = {24'd0, rx_head};
         IX_DIV:   rd_mux = div_q;
         IX_CTRL:  rd_mux = {24'd0, mode_q, 1'b0, par_q,
                              rx_full, rx_empty, tx_full, tx_empty};
         IX_RXCNT: rd_mux = 32'(rx_cnt);
         IX_TXCNT: rd_mux = 32'(tx_cnt);
         IX_SIZE:  rd_mux = 32'(size_q);
         IX_STOP:  rd_mux = two_q ? 32'd2 : 32'd1;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack    <= 1'b0;
         err    <= 1'b0;
         retry  <= 1'b0;
         rdata  <= '0;
         div_q  <= DIV_RESET;
         par_q  <= 1'b0;
         two_q  <= 1'b0;
         size_q <= 4'd8;
         mode_q <= BB_STALL;
      end else begin
         ack   <= (rk == RK_ACK);
         err   <= (rk == RK_ERR);
         retry <= (rk == RK_RTY);
         if (rk == RK_ACK) rdata <= (we || blocked) ? '0 : rd_mux;
         if (wr_cfg) begin
            case (idx)
               IX_DIV:  div_q <= wdata;
               IX_CTRL: begin
                  par_q  <= wdata[4];
                  mode_q <= bus_mode_e'(wdata[7:6]);
               end
               IX_SIZE: size_q <= clamp_size(wdata[7:0]);
               IX_STOP: two_q  <= pick_two_stop(wdata[7:0]);
               default: ;
            endcase
         end
      end
   end

   buf_uart_tick #(.DW(32)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
   );

   buf_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata[7:0]),
      .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty),
      .count(tx_cnt)
   );

   buf_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
      .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty),
      .count(rx_cnt)
   );

   buf_uart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .have(!tx_empty),
      .data(tx_head), .nbits(size_q), .par_en(par_q), .two_stop(two_q),
      .pop(tx_pop), .txd(txd)
   );

   buf_uart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .nbits(size_q), .par_en(par_q), .two_stop(two_q),
      .push(rx_push), .word(rx_word)
   );

endmodule

// File: rtl/buf_uart_chk.sv
module buf_uart_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req,
   input logic        we,
   input logic [2:0]  idx,
   input logic        ack,
   input logic        err,
   input logic        retry,
   input logic [31:0] rdata,
   input logic [1:0]  mode,
   input logic        tx_full,
   input logic        tx_empty,
   input logic        rx_full,
   input logic        rx_empty
);

   logic rd_empty_try;
   assign rd_empty_try = req && !(ack || err || retry) && !we
                         && (idx == 3'd0) && rx_empty;

   // R14
   resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack, err, retry}));

   // R14
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack || err || retry) |=> !(ack || err || retry));

   // R7
   err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($past(mode) == 2'd1));

   // R8
   retry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> ($past(mode) == 2'd2));

   // R9
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_empty_try && mode == 2'd3) |=> (ack && rdata == 32'd0));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_empty_try && mode == 2'd0) |=> !(ack || err || retry));

   // R2
   tx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));

   // R2
   rx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full && rx_empty));

endmodule

bind buf_uart buf_uart_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .we(we), .idx(idx),
   .ack(ack), .err(err), .retry(retry), .rdata(rdata), .mode(mode_q),
   .tx_full(tx_full), .tx_empty(tx_empty),
   .rx_full(rx_full), .rx_empty(rx_empty)
);

// File: tb/tb_buf_uart.sv
module tb_buf_uart;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ack, err, retry, txd, rxd;
   logic        loop_en = 1'b1, rx_drv = 1'b1;

   int n_chk = 0, n_fail = 0;

   typedef struct {
      logic [7:0] d;
      int         n;
      bit         p;
      bit         two;
   } exp_t;
   exp_t exp_q[$];

   // bench copy of the line configuration
   int cfg_n = 8;
   bit cfg_p = 0, cfg_two = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign rxd = loop_en ? txd : rx_drv;

   buf_uart #(.FIFO_DEPTH(4), .DIV_RESET(32'd1), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ack(ack), .err(err), .retry(retry),
      .txd(txd), .rxd(rxd)
   );

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
   endtask

   // kind: 0 none, 1 ack, 2 err, 3 retry
   task automatic bus(input bit w, input logic [4:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int kind,
                      output int waited);
      @(posedge clk); #1;
      req = 1'b1; we = w; addr = a; wdata = d;
      kind = 0; rd = '0; waited = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (ack || err || retry) begin
            kind = ack ? 1 : (err ? 2 : 3);
            rd = rdata;
            break;
         end
         waited++;
      end
      @(posedge clk); #1;
      req = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      logic [31:0] rd; int k, w;
      bus(1'b1, a, d, rd, k, w);
      if (k != 1) check("bus write ack", k, 1);
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a,
                         input logic [31:0] exp);
      logic [31:0] rd; int k, w;
      bus(1'b0, a, '0, rd, k, w);
      check(tag, (k == 1) ? rd : 32'hdead0000 + k, exp);
   endtask

   task automatic send_tx(input logic [7:0] d);
      exp_t e;
      e.d = d & 8'((1 << cfg_n) - 1); e.n = cfg_n; e.p = cfg_p; e.two = cfg_two;
      exp_q.push_back(e);
      wr(5'h00, {24'd0, d});
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (40) @(negedge clk);
   endtask

   task automatic line_bit(input logic v);
      rx_drv = v;
      repeat (16) @(posedge clk);
      #1;
   endtask

   task automatic rx_frame(input logic [7:0] d, input logic pb,
                           input logic stopv);
      @(posedge clk); #1;
      line_bit(1'b0);
      for (int i = 0; i < 8; i++) line_bit(d[i]);
      line_bit(pb);
      line_bit(stopv);
      line_bit(1'b1);
      line_bit(1'b1);
   endtask

   // Monitor: decodes txd independently and scores against exp_q.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            logic [7:0] got; logic pb; exp_t e;
            got = '0; pb = 1'b0;
            repeat (8) @(negedge clk);
            check("R4 start bit low", txd, 0);
            if (exp_q.size() == 0) begin
               check("R4 unexpected frame", 1, 0);
               e.d = '0; e.n = 8; e.p = 0; e.two = 0;
            end else begin
               e = exp_q[0];
            end
            for (int i = 0; i < e.n; i++) begin
               repeat (16) @(negedge clk);
               got[i] = txd;
            end
            if (e.p) begin
               repeat (16) @(negedge clk);
               pb = txd;
               check("R5 even parity", ^{got, pb}, 0);
            end
            repeat (16) @(negedge clk);
            check("R4 stop bit", txd, 1);
            if (e.two) begin
               repeat (16) @(negedge clk);
               check("R4 second stop bit", txd, 1);
            end
            check("R4 frame data LSB first", got, e.d);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd; int k, w;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      check("R4 txd idle high", txd, 1);
      rd_chk("R2 ctrl reset value", 5'h08, 32'h05);
      rd_chk("R1 divisor reset value", 5'h04, 32'd1);
      rd_chk("R3 size reset value", 5'h14, 32'd8);
      rd_chk("R3 stop reset value", 5'h18, 32'd1);

      // R1 divisor read-back
      wr(5'h04, 32'h1234_5673);
      rd_chk("R1 divisor readback", 5'h04, 32'h1234_5673);
      wr(5'h04, 32'd1);

      // R3 clamping
      wr(5'h14, 32'd3);  rd_chk("R3 size low clamp", 5'h14, 32'd5);
      wr(5'h14, 32'd12); rd_chk("R3 size high clamp", 5'h14, 32'd8);
      wr(5'h14, 32'd6);  rd_chk("R3 size in range", 5'h14, 32'd6);
      wr(5'h18, 32'd0);  rd_chk("R3 stop zero", 5'h18, 32'd1);
      wr(5'h18, 32'd7);  rd_chk("R3 stop large", 5'h18, 32'd2);
      wr(5'h14, 32'd8);  wr(5'h18, 32'd1);

      // R11 flag bits are read-only
      wr(5'h08, 32'h0F);
      rd_chk("R11 flag write ignored", 5'h08, 32'h05);

      // R4 / R6 loopback, 8N1
      cfg_n = 8; cfg_p = 0; cfg_two = 0;
      send_tx(8'hA5);
      send_tx(8'h3C);
      wait_drain();
      rd_chk("R6 rx count", 5'h0C, 32'd2);
      rd_chk("R6 rx first word", 5'h00, 32'hA5);
      rd_chk("R6 rx second word", 5'h00, 32'h3C);
      rd_chk("R2 rx empty after drain", 5'h08, 32'h05);

      // R5 parity, 7 bits, 2 stops
      wr(5'h08, 32'h10); wr(5'h14, 32'd7); wr(5'h18, 32'd2);
      cfg_n = 7; cfg_p = 1; cfg_two = 1;
      send_tx(8'h55);
      send_tx(8'hAA);
      wait_drain();
      rd_chk("R5 rx parity word 1", 5'h00, 32'h55);
      rd_chk("R5 rx parity word 2 (upper bit cleared)", 5'h00, 32'h2A);

      wr(5'h14, 32'd8); wr(5'h18, 32'd1);
      cfg_n = 8; cfg_p = 0; cfg_two = 0;

      // R7 error on empty read
      wr(5'h08, 32'h40);
      bus(1'b0, 5'h00, '0, rd, k, w);
      check("R7 empty read gives err", k, 2);
      rd_chk("R7 state unchanged", 5'h08, 32'h45);

      // R8 retry on empty read
      wr(5'h08, 32'h80);
      bus(1'b0, 5'h00, '0, rd, k, w);
      check("R8 empty read gives retry", k, 3);
      rd_chk("R8 state unchanged", 5'h08, 32'h85);

      // R9 ack on empty read returns 0
      wr(5'h08, 32'hC0);
      bus(1'b0, 5'h00, '0, rd, k, w);
      check("R9 empty read acked", k, 1);
      check("R9 empty read data", rd, 32'd0);
      @(negedge clk);
      check("R14 single response pulse", {ack, err, retry}, 3'b000);

      // R13 / R10 / R9 transmit buffer full, loopback off
      loop_en = 1'b0;
      wr(5'h08, 32'h00);
      for (int i = 1; i <= 5; i++) send_tx(8'(8'h11 * i));
      rd_chk("R13 tx full flag", 5'h08, 32'h06);
      rd_chk("R6 tx count at full", 5'h10, 32'd4);
      begin
         exp_t e;
         e.d = 8'h66; e.n = 8; e.p = 0; e.two = 0;
         exp_q.push_back(e);
      end
      bus(1'b1, 5'h00, 32'h66, rd, k, w);
      check("R10 stalled write completes", k, 1);
      check("R10 write held off", (w > 50) ? 1 : 0, 1);
      wr(5'h08, 32'hC0);
      bus(1'b1, 5'h00, 32'h99, rd, k, w);
      check("R9 write to full acked at once", k, 1);
      rd_chk("R9 dropped word not stored", 5'h10, 32'd4);
      wr(5'h08, 32'h40);
      bus(1'b1, 5'h00, 32'h77, rd, k, w);
      check("R7 write to full gives err", k, 2);
      wait_drain();
      rd_chk("R13 tx empty after drain", 5'h08, 32'h45);

      // R12 receive error frames, bench drives the line
      wr(5'h08, 32'h10);
      rx_frame(8'h01, 1'b0, 1'b1);   // odd parity
      repeat (20) @(posedge clk);
      rd_chk("R12 bad parity dropped", 5'h0C, 32'd0);
      rx_frame(8'h03, 1'b0, 1'b0);   // low stop bit
      repeat (20) @(posedge clk);
      rd_chk("R12 bad stop dropped", 5'h0C, 32'd0);
      rx_frame(8'h81, 1'b0, 1'b1);   // clean frame
      repeat (20) @(posedge clk);
      rd_chk("R12 good frame kept", 5'h0C, 32'd1);
      rd_chk("R6 good frame data", 5'h00, 32'h81);

      repeat (10) @(posedge clk);
      finish_run();
   end

endmodule